// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the bus-facing half of a digitally controlled potentiometer. It listens on an already synchronized two-wire bus (serial clock and serial data), recognises START and STOP, and accepts an identification byte made of the fixed type nibble 0101, a zero bit, the two strap-pin address bits and the read/write flag. It then takes an instruction byte that names one of six commands and one of four stored registers. The slave answers on the data line through an open-drain pull-down enable.

Transfer commands end after the instruction byte. Read and write commands carry one 10-bit value in two bytes: the upper byte holds the two top bits in its low positions, and the lower byte holds bits 7..0. Writes and transfers reach the register controller as a one-cycle request, and only at the STOP that closes a complete, fully acknowledged command. Reads take their data from the controller, which muxes it using the command and index outputs. When the controller reports a nonvolatile write in progress, the slave does not acknowledge its address, so the master can poll until the write is done.

Top module: `pot_cmd_slave`

## Requirements
- R1: After reset, `sda_pull_o` and `req_valid_o` are 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked before any START get no acknowledge.
- R3: The identification byte is acknowledged only when its bits 7..4 are 0101, bit 3 is 0 and bits 2..1 equal `strap_i`. Bit 0 is read/write, with 1 meaning read. A mismatching byte gets no acknowledge, and the slave stays silent until the next START.
- R4: While `busy_i` is 1 at the acknowledge slot of a matching identification byte, that byte is not acknowledged.
- R5: The instruction byte holds the opcode in bits 7..5 and the register index in bits 3..2. Bits 4, 1 and 0 are reserved and must be 0. The accepted {read/write, opcode} pairs are: 1/100 read wiper (code 1), 0/101 write wiper (code 2), 1/101 read register (code 3), 0/110 write register (code 4), 1/110 register-to-wiper transfer (code 5), 0/111 wiper-to-register transfer (code 6). Any other pair, or a reserved bit set to 1, gets no acknowledge and no request.
- R6: `sda_pull_o` changes only while SCL is low, that is, after a falling SCL edge.
- R7: On a write command, each of the two data bytes is acknowledged. The value is taken from bits 1..0 of the first data byte (as value bits 9..8) and from the second data byte (as bits 7..0).
- R8: On a read command, the slave sends {six 0 bits, value[9:8]} and then value[7:0], MSB first. It sends the second byte only if the master acknowledged the first.
- R9: A transfer command (codes 5 and 6) followed by STOP after the acknowledged instruction byte produces a request carrying its code and register index.
- R10: Requests are issued only for codes 2, 4, 5 and 6, and only in the cycle after a STOP that ends a complete command. A START or STOP arriving before the command is complete cancels it, and so does a repeated START after a complete write.
- R11: `req_valid_o` is high for exactly one cycle for each request, with `req_cmd_o`, `req_idx_o` and `req_wdata_o` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| strap_i | input | 2 | Strap address pins |
| busy_i | input | 1 | Nonvolatile write in progress |
| rd_data_i | input | VAL_W | Read value for the current command and index |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_cmd_o | output | 3 | Decoded command code |
| req_idx_o | output | 2 | Register index |
| req_wdata_o | output | VAL_W | Write value |

## Verification
Each of the six commands is run as a full bus transaction against a behavioural register model. Reading values back after writes and transfers shows that the bit placement across the two data bytes and the direction of each transfer are right. Malformed identification and instruction bytes, each differing from a valid one in a single field, show which field the slave actually decodes. A repeated START and a mid-byte START separate "complete command" from "committed command". A master NACK after the first read byte shows that the slave stops driving. Address polling against a busy window shows that the acknowledge is withheld while busy and returns once the write completes.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 2;
    localparam int STRAP_W = 2;
    localparam int CNT_W  = 4;
    localparam logic [3:0] TYPE_NIBBLE = 4'b0101;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_RD_WCR  = 3'd1,
        CMD_WR_WCR  = 3'd2,
        CMD_RD_DR   = 3'd3,
        CMD_WR_DR   = 3'd4,
        CMD_XFR_D2W = 3'd5,
        CMD_XFR_W2D = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_RX,
        PH_TX,
        PH_HOLD
    } phase_e;

    // Opcode meaning depends on the read/write flag of the identification byte.
    function automatic cmd_e decode_cmd(input logic [2:0] opc, input logic rd);
        cmd_e c;
        case ({rd, opc})
            4'b1100: c = CMD_RD_WCR;
            4'b0101: c = CMD_WR_WCR;
            4'b1101: c = CMD_RD_DR;
            4'b0110: c = CMD_WR_DR;
            4'b1110: c = CMD_XFR_D2W;
            4'b0111: c = CMD_XFR_W2D;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic logic cmd_is_read(input cmd_e c);
        return (c == CMD_RD_WCR) || (c == CMD_RD_DR);
    endfunction

    function automatic logic cmd_is_xfer(input cmd_e c);
        return (c == CMD_XFR_D2W) || (c == CMD_XFR_W2D);
    endfunction

endpackage

// File: rtl/pot_bus_edges.sv
module pot_bus_edges (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/pot_bit_timer.sv
module pot_bit_timer
    import pot_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_open,
    output logic              ack_close,
    output logic              ack_level,
    output logic              tx_step,
    output logic [2:0]        tx_pos
);
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt_q;
    logic              seen_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            shreg_q <= '0;
            lvl_q   <= 1'b1;
        end else if (active) begin
            if (scl_rise) begin
                if (cnt_q != SLOT) begin
                    shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
                    cnt_q   <= cnt_q + 1'b1;
                end else begin
                    seen_q <= 1'b1;
                    lvl_q  <= sda_i;
                end
            end else if (scl_fall && cnt_q == SLOT && seen_q) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
            end
        end
    end

    assign rx_byte   = shreg_q;
    assign ack_level = lvl_q;
    assign ack_open  = active & scl_fall & (cnt_q == SLOT) & ~seen_q;
    assign ack_close = active & scl_fall & (cnt_q == SLOT) & seen_q;
    assign tx_step   = active & scl_fall & (cnt_q != '0) & (cnt_q != SLOT);
    assign tx_pos    = 3'(SLOT - 1'b1 - cnt_q);
endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave
    import pot_cmd_pkg::*;
#(
    parameter int VAL_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [VAL_W-1:0]   rd_data_i,
    output logic               sda_pull_o,
    output logic               req_valid_o,
    output logic [2:0]         req_cmd_o,
    output logic [IDX_W-1:0]   req_idx_o,
    output logic [VAL_W-1:0]   req_wdata_o
);
    localparam int HI_W = VAL_W - BYTE_W;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic ack_open, ack_close, ack_level, tx_step;
    logic [2:0] tx_pos;

    phase_e             phase_q;
    logic               rw_q;
    logic               second_q;
    logic               pull_q;
    logic               armed_q;
    logic               valid_q;
    cmd_e               cmd_q;
    logic [IDX_W-1:0]   idx_q;
    logic [VAL_W-1:0]   wdata_q;
    logic [VAL_W-1:0]   txval_q;
    logic [BYTE_W-1:0]  txbyte_q;

    logic               timer_active;
    logic               addr_match;
    cmd_e               instr_cmd;
    logic               instr_ok;
    logic [BYTE_W-1:0]  rd_hi;

    pot_bus_edges u_edges (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign timer_active = (phase_q == PH_ADDR) || (phase_q == PH_INSTR) ||
                          (phase_q == PH_RX)   || (phase_q == PH_TX);

    pot_bit_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_det),
        .active    (timer_active),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_i     (sda_i),
        .rx_byte   (rx_byte),
        .ack_open  (ack_open),
        .ack_close (ack_close),
        .ack_level (ack_level),
        .tx_step   (tx_step),
        .tx_pos    (tx_pos)
    );

    assign addr_match = (rx_byte[7:4] == TYPE_NIBBLE) && !rx_byte[3] &&
                        (rx_byte[2:1] == strap_i) && !busy_i;
    assign instr_cmd  = decode_cmd(rx_byte[7:5], rw_q);
    assign instr_ok   = !rx_byte[4] && (rx_byte[1:0] == 2'b00) &&
                        (instr_cmd != CMD_NONE);
    assign rd_hi      = BYTE_W'(rd_data_i >> BYTE_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            rw_q     <= 1'b0;
            second_q <= 1'b0;
            pull_q   <= 1'b0;
            armed_q  <= 1'b0;
            valid_q  <= 1'b0;
            cmd_q    <= CMD_NONE;
            idx_q    <= '0;
            wdata_q  <= '0;
            txval_q  <= '0;
            txbyte_q <= '0;
        end else begin
            valid_q <= 1'b0;
            if (start_det) begin
                phase_q <= PH_ADDR;
                pull_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (stop_det) begin
                valid_q <= (phase_q == PH_HOLD) && armed_q;
                phase_q <= PH_IDLE;
                pull_q  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (tx_step && phase_q == PH_TX) begin
                    pull_q <= ~txbyte_q[tx_pos];
                end
                if (ack_open) begin
                    case (phase_q)
                        PH_ADDR: begin
                            if (addr_match) begin
                                pull_q <= 1'b1;
                                rw_q   <= rx_byte[0];
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_INSTR: begin
                            if (instr_ok) begin
                                pull_q <= 1'b1;
                                cmd_q  <= instr_cmd;
                                idx_q  <= rx_byte[3:2];
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_RX: begin
                            pull_q <= 1'b1;
                            if (!second_q) begin
                                wdata_q[VAL_W-1:BYTE_W] <= rx_byte[HI_W-1:0];
                            end else begin
                                wdata_q[BYTE_W-1:0] <= rx_byte;
                            end
                        end
                        PH_TX:   pull_q <= 1'b0;
                        default: ;
                    endcase
                end
                if (ack_close) begin
                    pull_q <= 1'b0;
                    case (phase_q)
                        PH_ADDR: phase_q <= PH_INSTR;
                        PH_INSTR: begin
                            second_q <= 1'b0;
                            if (cmd_is_xfer(cmd_q)) begin
                                phase_q <= PH_HOLD;
                                armed_q <= 1'b1;
                            end else if (cmd_is_read(cmd_q)) begin
                                phase_q  <= PH_TX;
                                txval_q  <= rd_data_i;
                                txbyte_q <= rd_hi;
                                pull_q   <= ~rd_hi[BYTE_W-1];
                            end else begin
                                phase_q <= PH_RX;
                            end
                        end
                        PH_RX: begin
                            if (!second_q) begin
                                second_q <= 1'b1;
                            end else begin
                                phase_q <= PH_HOLD;
                                armed_q <= 1'b1;
                            end
                        end
                        PH_TX: begin
                            if (!ack_level && !second_q) begin
                                second_q <= 1'b1;
                                txbyte_q <= txval_q[BYTE_W-1:0];
                                pull_q   <= ~txval_q[BYTE_W-1];
                            end else begin
                                phase_q <= PH_HOLD;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_pull_o  = pull_q;
    assign req_valid_o = valid_q;
    assign req_cmd_o   = cmd_q;
    assign req_idx_o   = idx_q;
    assign req_wdata_o = wdata_q;
endmodule

// File: rtl/pot_cmd_checker.sv
module pot_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_pull_o,
    input logic       req_valid_o,
    input logic [2:0] req_cmd_o
);
    assert_pull_steady_scl_high_R6: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    assert_req_single_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |=> !req_valid_o);

    assert_req_kind_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_cmd_o == 3'd2 || req_cmd_o == 3'd4 ||
                         req_cmd_o == 3'd5 || req_cmd_o == 3'd6));

    assert_req_after_stop_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> ($past(sda_i) && !$past(sda_i, 2) &&
                         $past(scl_i) && $past(scl_i, 2)));
endmodule

bind pot_cmd_slave pot_cmd_checker u_pot_cmd_checker (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_pull_o  (sda_pull_o),
    .req_valid_o (req_valid_o),
    .req_cmd_o   (req_cmd_o)
);

// File: tb/test_pot_cmd_slave.sv
module test_pot_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int VAL_W = 10;
    localparam logic [1:0] STRAP = 2'b10;
    localparam int BUSY_CYCLES = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic busy;
    logic [VAL_W-1:0] rd_data;
    logic sda_pull, req_valid;
    logic [2:0] req_cmd;
    logic [1:0] req_idx;
    logic [VAL_W-1:0] req_wdata;

    int n_checks = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    logic [VAL_W-1:0] m_wcr = '0;
    logic [VAL_W-1:0] m_dr [4] = '{default: '0};
    logic [14:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;
    assign busy = (busy_cnt != 0);
    always_comb rd_data = (req_cmd == 3'd1) ? m_wcr : m_dr[req_idx];

    pot_cmd_slave #(.VAL_W(VAL_W)) i_pot_cmd_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
        .busy_i(busy), .rd_data_i(rd_data), .sda_pull_o(sda_pull),
        .req_valid_o(req_valid), .req_cmd_o(req_cmd), .req_idx_o(req_idx),
        .req_wdata_o(req_wdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference register model, compared against the request port on every clock.
    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!rst && req_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected request", 1, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk("R11 request cmd", int'(req_cmd), int'(e[14:12]));
                chk("R11 request idx", int'(req_idx), int'(e[11:10]));
                if (e[14:12] == 3'd2 || e[14:12] == 3'd4)
                    chk("R7 request data", int'(req_wdata), int'(e[9:0]));
            end
            case (req_cmd)
                3'd2: m_wcr = req_wdata;
                3'd4: begin m_dr[req_idx] = req_wdata; busy_cnt = BUSY_CYCLES; end
                3'd5: m_wcr = m_dr[req_idx];
                3'd6: begin m_dr[req_idx] = m_wcr; busy_cnt = BUSY_CYCLES; end
                default: ;
            endcase
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(2); scl = 1'b1; tick(4); scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(2); scl = 1'b1; tick(2); b = sda_bus; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2); scl = 1'b1; tick(3); sda_m = 1'b0; tick(3);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(2); scl = 1'b1; tick(3); sda_m = 1'b1; tick(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(x);
        acked = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(b[i]);
        send_bit(~mack);
    endtask

    function automatic logic [7:0] id_byte(input logic [1:0] a, input logic rd);
        return {4'b0101, 1'b0, a, rd};
    endfunction

    function automatic logic [7:0] ins_byte(input logic [2:0] op, input logic [1:0] idx);
        return {op, 1'b0, idx, 2'b00};
    endfunction

    task automatic do_write(input logic [2:0] op, input logic [2:0] code,
                            input logic [1:0] idx, input logic [VAL_W-1:0] v);
        logic a;
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), a); chk("R3 id ack (write)", a, 1);
        send_byte(ins_byte(op, idx), a);    chk("R5 instr ack (write)", a, 1);
        send_byte({6'b0, v[9:8]}, a);       chk("R7 data hi ack", a, 1);
        send_byte(v[7:0], a);               chk("R7 data lo ack", a, 1);
        exp_q.push_back({code, idx, v});
        bus_stop();
        tick(4);
    endtask

    task automatic do_read(input logic [2:0] op, input logic [1:0] idx,
                           input logic [VAL_W-1:0] v, input string tag);
        logic a;
        logic [7:0] hi, lo;
        bus_start();
        send_byte(id_byte(STRAP, 1'b1), a); chk("R3 id ack (read)", a, 1);
        send_byte(ins_byte(op, idx), a);    chk("R5 instr ack (read)", a, 1);
        recv_byte(hi, 1'b1);
        recv_byte(lo, 1'b0);
        chk({tag, " R8 read hi"}, hi, {6'b0, v[9:8]});
        chk({tag, " R8 read lo"}, lo, v[7:0]);
        bus_stop();
        tick(4);
    endtask

    task automatic do_xfer(input logic rd, input logic [2:0] op, input logic [2:0] code,
                           input logic [1:0] idx);
        logic a;
        bus_start();
        send_byte(id_byte(STRAP, rd), a);  chk("R9 xfer id ack", a, 1);
        send_byte(ins_byte(op, idx), a);   chk("R9 xfer instr ack", a, 1);
        exp_q.push_back({code, idx, 10'h0});
        bus_stop();
        tick(4);
    endtask

    task automatic bad_instr(input logic rd, input logic [7:0] ib, input string tag);
        logic a;
        bus_start();
        send_byte(id_byte(STRAP, rd), a); chk({tag, " R5 id ack"}, a, 1);
        send_byte(ib, a);                 chk({tag, " R5 instr nack"}, a, 0);
        bus_stop();
        tick(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] hi;
        int tries;
        tick(5);
        rst = 1'b0;
        tick(1);
        chk("R1 reset sda_pull", sda_pull, 0);
        chk("R1 reset req_valid", req_valid, 0);

        // R2: a byte clocked before any START is not acknowledged
        scl = 1'b0; tick(2);
        send_byte(id_byte(STRAP, 1'b0), a); chk("R2 no ack before START", a, 0);
        bus_stop(); tick(4);

        // R7 write wiper, R8 read it back
        do_write(3'b101, 3'd2, 2'd0, 10'h2A5);
        do_read(3'b100, 2'd0, 10'h2A5, "wcr");

        // R7 write register 2, then R4 address polling while busy
        do_write(3'b110, 3'd4, 2'd2, 10'h13C);
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), a); chk("R4 no ack while busy", a, 0);
        bus_stop();
        tries = 0;
        do begin
            tick(20);
            bus_start();
            send_byte(id_byte(STRAP, 1'b0), a);
            bus_stop();
            tries++;
        end while (!a && tries < 40);
        chk("R4 ack after busy clears", a, 1);
        tick(4);
        do_read(3'b101, 2'd2, 10'h13C, "dr2");

        // R9 transfers
        do_xfer(1'b1, 3'b110, 3'd5, 2'd2);
        do_read(3'b100, 2'd0, 10'h13C, "wcr after d2w");
        do_write(3'b101, 3'd2, 2'd0, 10'h0C3);
        do_xfer(1'b0, 3'b111, 3'd6, 2'd1);
        tick(BUSY_CYCLES + 20);
        do_read(3'b101, 2'd1, 10'h0C3, "dr1 after w2d");

        // R3 mismatching identification bytes
        bus_start();
        send_byte(id_byte(2'b01, 1'b0), a); chk("R3 wrong strap nack", a, 0);
        send_byte(ins_byte(3'b101, 2'd0), a); chk("R3 silent after mismatch", a, 0);
        bus_stop(); tick(4);
        bus_start();
        send_byte({4'b0110, 1'b0, STRAP, 1'b0}, a); chk("R3 wrong type nack", a, 0);
        bus_stop(); tick(4);
        bus_start();
        send_byte({4'b0101, 1'b1, STRAP, 1'b0}, a); chk("R3 bit3 set nack", a, 0);
        bus_stop(); tick(4);

        // R5 malformed instructions
        bad_instr(1'b0, {3'b101, 1'b1, 2'd0, 2'b00}, "reserved bit4");
        bad_instr(1'b0, {3'b101, 1'b0, 2'd0, 2'b01}, "reserved bit0");
        bad_instr(1'b0, ins_byte(3'b100, 2'd0), "write/100");
        bad_instr(1'b1, ins_byte(3'b111, 2'd0), "read/111");

        // R10 START in the middle of a data byte cancels the write
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), a);
        send_byte(ins_byte(3'b101, 2'd0), a);
        send_byte(8'h03, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        bus_stop(); tick(4);
        do_read(3'b100, 2'd0, 10'h0C3, "R10 wcr after abort");

        // R10 repeated START after a complete write cancels it
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), a);
        send_byte(ins_byte(3'b101, 2'd0), a);
        send_byte(8'h01, a);
        send_byte(8'h11, a); chk("R10 last byte acked", a, 1);
        bus_start();
        bus_stop(); tick(4);
        do_read(3'b100, 2'd0, 10'h0C3, "R10 wcr after restart");

        // R8 master NACKs the first read byte: slave releases the line
        bus_start();
        send_byte(id_byte(STRAP, 1'b1), a);
        send_byte(ins_byte(3'b101, 2'd2), a);
        recv_byte(hi, 1'b0);
        chk("R8 hi byte before nack", hi, 8'h01);
        recv_byte(hi, 1'b0);
        chk("R8 released after nack", hi, 8'hFF);
        bus_stop(); tick(10);

        chk("R10 no pending requests", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule